// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects interrupt requests from six on-chip peripheral sources and three external pins, and hands them to a processor as two prioritised request lines plus one non-maskable line. Level 1 is the higher level. Each source carries an enable bit and a level-select bit. A status register holds one global enable for each level.

The two timer sources each merge a vector of event flags into one request. The other four peripheral sources arrive as single level-sensitive lines. Each external pin passes through a two-flop synchronizer and an edge detector whose polarity software selects. A detected edge sets a sticky flag, and software clears it by writing 1. External pin 0 can be promoted to the non-maskable line, and that choice can only be changed while the privilege input is high. A pin whose interrupt function is not needed can be switched to general-purpose use. Pins 1 and 2 can then drive an output, while pin 0 stays input-only.

Software reaches the block through a simple synchronous register port. A write takes effect on the clock edge where `wr_en` is high. Read data is registered from the address one cycle earlier.

Top module: `irq2_ctrl`

## Requirements
- R1: After a synchronous reset, every register at addresses 0 to 5 reads 0, and `irq_l1`, `irq_l2`, `irq_nmi`, `ext_oe` and `ext_out` are all 0. Reset selects rising-edge polarity, level 1 and all enables off.
- R2: A timer source requests whenever any bit of its event slice is set. Timer t owns `tmr_ev[t*6 +: 6]` and is source bit t.
- R3: One cycle after its inputs, `irq_l1` equals the level-1 global enable ANDed with the OR of enabled requesting sources whose level bit is 0. `irq_l2` is formed the same way from the level-2 global enable and level bit 1. The source map is: bits 1:0 timers, bits 5:2 `per_req`. Enables are at address 3, level bits at address 4, and the global enables at address 5 (bit 0 for level 1, bit 1 for level 2).
- R4: External pin e has a configuration register at address e. Bit 2 selects the edge: 0 means rising, 1 means falling. An edge of the selected kind sets flag bit 3 within four clock cycles. An edge of the other kind leaves the flag unchanged.
- R5: An external flag stays set until a write to its register with bit 3 equal to 1. A write with bit 3 equal to 0 leaves the flag set.
- R6: A set external flag requests on the level chosen by bit 1 of its register, gated by enable bit 0 and by that level's global enable.
- R7: When bit 7 of register 0 is 1, the pin 0 flag drives `irq_nmi` one cycle later, regardless of its enable and the global enables. While bit 7 is 1, that flag never reaches `irq_l1` or `irq_l2`.
- R8: Writes to bit 7 of register 0 take effect only while `priv_i` is 1; otherwise the bit keeps its value.
- R9: Bit 4 of an external register selects general-purpose mode, in which no edge sets the flag. `ext_out[e]` follows bit 5, and `ext_oe[e]` equals bit 4 AND bit 6 for pins 1 and 2. Pin 0 never drives `ext_oe`, and its bit 6 reads 0.
- R10: Address 6 reads the synchronized levels of `ext_in` in bits 2:0.
- R11: `rdata` shows, one cycle later, the register selected by `addr`. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 1 | Privileged mode; high allows the non-maskable select to change |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| tmr_ev | input | 12 | Event flags of the two timers, 6 per timer |
| per_req | input | 4 | Single-line peripheral requests |
| ext_in | input | 3 | External interrupt pins |
| ext_out | output | 3 | General-purpose output data |
| ext_oe | output | 3 | General-purpose output enable |
| irq_l1 | output | 1 | Level-1 (higher) request |
| irq_l2 | output | 1 | Level-2 request |
| irq_nmi | output | 1 | Non-maskable request |

## Verification
The bench builds the block with its default parameters: two timers of six events, four plain peripheral lines, three pins and a two-stage synchronizer. This size makes every source-map bit and every pin role reachable: the non-maskable pin, the input-only pin and the two output-capable pins. Random register settings and request patterns exercise the level routing against a bench-side model. Directed sequences cover both edge polarities, the sticky flag, the privilege lock and general-purpose mode.

// File: rtl/irq2_pkg.sv
package irq2_pkg;
  localparam int DW = 8;

  // external pin configuration, bit 7 down to bit 0
  typedef struct packed {
    logic nmi;   // 7 promote to non-maskable (pin 0, privileged)
    logic dir;   // 6 drive pin in gpio mode (pins 1,2)
    logic dout;  // 5 gpio output data
    logic gpio;  // 4 gpio mode, interrupt function off
    logic flag;  // 3 sticky edge flag, write 1 clears
    logic fall;  // 2 1 = falling edge
    logic lvl2;  // 1 route to level 2
    logic en;    // 0 source enable
  } ext_cfg_t;

  localparam int A_PEN  = 3;
  localparam int A_PPRI = 4;
  localparam int A_GIE  = 5;
  localparam int A_PIN  = 6;
endpackage

// File: rtl/ext_pin_unit.sv
module ext_pin_unit
  import irq2_pkg::*;
#(
  parameter int SYNC    = 2,
  parameter bit HAS_OUT = 1'b1,
  parameter bit HAS_NMI = 1'b0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     pin_i,
  input  logic     priv_i,
  input  logic     cfg_wr,
  input  ext_cfg_t wcfg,
  output ext_cfg_t cfg,
  output logic     pin_sync,
  output logic     pin_out,
  output logic     pin_oe
);
  logic [SYNC:0] sh;
  logic          hit;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC-1:0], pin_i};
  end

  assign pin_sync = sh[SYNC-1];
  assign hit = !cfg.gpio &&
               (cfg.fall ? (sh[SYNC] && !sh[SYNC-1]) : (!sh[SYNC] && sh[SYNC-1]));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else begin
      cfg.flag <= hit || (cfg.flag && !(cfg_wr && wcfg.flag));
      if (cfg_wr) begin
        cfg.en   <= wcfg.en;
        cfg.lvl2 <= wcfg.lvl2;
        cfg.fall <= wcfg.fall;
        cfg.gpio <= wcfg.gpio;
        cfg.dout <= wcfg.dout;
        cfg.dir  <= HAS_OUT ? wcfg.dir : 1'b0;
        if (HAS_NMI && priv_i) cfg.nmi <= wcfg.nmi;
      end
    end
  end

  assign pin_out = cfg.dout;
  assign pin_oe  = HAS_OUT ? (cfg.gpio && cfg.dir) : 1'b0;

  // R5: a flag only drops on a write-1 clear
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg.flag && !(cfg_wr && wcfg.flag)) |=> cfg.flag);
  // R9: no flag can rise while the pin is in gpio mode
  p_gpio_no_flag_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg.flag) |-> $past(!cfg.gpio));
  // R8: the non-maskable select is locked outside privileged mode
  p_nmi_lock_r8: assert property (@(posedge clk) disable iff (rst)
    !priv_i |=> $stable(cfg.nmi));
endmodule

// File: rtl/src_router.sv
module src_router #(
  parameter int N = 9
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] en,
  input  logic [N-1:0] lvl2,
  input  logic         gie1,
  input  logic         gie2,
  output logic         l1,
  output logic         l2
);
  logic [N-1:0] live;
  assign live = req & en;
  assign l1 = gie1 && |(live & ~lvl2);
  assign l2 = gie2 && |(live & lvl2);
endmodule

// File: rtl/irq2_ctrl.sv
module irq2_ctrl
  import irq2_pkg::*;
#(
  parameter int N_TMR  = 2,
  parameter int TMR_EV = 6,
  parameter int N_OTH  = 4,
  parameter int N_EXT  = 3,
  parameter int SYNC   = 2,
  parameter int AW     = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    priv_i,
  input  logic                    wr_en,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  input  logic [N_TMR*TMR_EV-1:0] tmr_ev,
  input  logic [N_OTH-1:0]        per_req,
  input  logic [N_EXT-1:0]        ext_in,
  output logic [N_EXT-1:0]        ext_out,
  output logic [N_EXT-1:0]        ext_oe,
  output logic                    irq_l1,
  output logic                    irq_l2,
  output logic                    irq_nmi
);
  localparam int N_SRC = N_TMR + N_OTH;
  localparam int N_ALL = N_SRC + N_EXT;

  logic [N_TMR-1:0] tmr_req;
  logic [N_SRC-1:0] pen, ppri;
  logic [1:0]       gie;
  ext_cfg_t         cfg [N_EXT];
  logic [N_EXT-1:0] ext_sync, ext_req, ext_en, ext_l2;
  logic             l1_d, l2_d;

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    assign tmr_req[t] = |tmr_ev[t*TMR_EV +: TMR_EV];
  end

  for (genvar e = 0; e < N_EXT; e++) begin : g_ext
    ext_pin_unit #(
      .SYNC(SYNC), .HAS_OUT(e != 0), .HAS_NMI(e == 0)
    ) u_pin (
      .clk(clk), .rst(rst), .pin_i(ext_in[e]), .priv_i(priv_i),
      .cfg_wr(wr_en && (addr == AW'(e))), .wcfg(ext_cfg_t'(wdata)),
      .cfg(cfg[e]), .pin_sync(ext_sync[e]),
      .pin_out(ext_out[e]), .pin_oe(ext_oe[e])
    );
    assign ext_req[e] = cfg[e].flag && !cfg[e].nmi;
    assign ext_en[e]  = cfg[e].en;
    assign ext_l2[e]  = cfg[e].lvl2;
  end

  src_router #(.N(N_ALL)) u_route (
    .req({ext_req, per_req, tmr_req}),
    .en({ext_en, pen}),
    .lvl2({ext_l2, ppri}),
    .gie1(gie[0]), .gie2(gie[1]),
    .l1(l1_d), .l2(l2_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pen <= '0; ppri <= '0; gie <= '0;
    end else if (wr_en) begin
      if (addr == AW'(A_PEN))  pen  <= wdata[N_SRC-1:0];
      if (addr == AW'(A_PPRI)) ppri <= wdata[N_SRC-1:0];
      if (addr == AW'(A_GIE))  gie  <= wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_l1 <= 1'b0; irq_l2 <= 1'b0; irq_nmi <= 1'b0; rdata <= '0;
    end else begin
      irq_l1  <= l1_d;
      irq_l2  <= l2_d;
      irq_nmi <= cfg[0].flag && cfg[0].nmi;
      if (int'(addr) < N_EXT)       rdata <= cfg[addr];
      else if (addr == AW'(A_PEN))  rdata <= DW'(pen);
      else if (addr == AW'(A_PPRI)) rdata <= DW'(ppri);
      else if (addr == AW'(A_GIE))  rdata <= DW'(gie);
      else if (addr == AW'(A_PIN))  rdata <= DW'(ext_sync);
      else                          rdata <= '0;
    end
  end

  // R3: a cleared global enable silences its level on the next cycle
  p_gie1_gate_r3: assert property (@(posedge clk) disable iff (rst)
    !gie[0] |=> !irq_l1);
  p_gie2_gate_r3: assert property (@(posedge clk) disable iff (rst)
    !gie[1] |=> !irq_l2);
  // R7: a promoted pin 0 flag reaches the non-maskable line, unmasked
  p_nmi_unmasked_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg[0].flag && cfg[0].nmi) |=> irq_nmi);
endmodule

// File: tb/tb_irq2_ctrl.sv
`timescale 1ns/1ps
module tb_irq2_ctrl;
  logic clk = 0, rst = 1, priv_i = 1, wr_en = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata, v;
  logic [11:0] tmr_ev = '0;
  logic [3:0] per_req = '0;
  logic [2:0] ext_in = '0, ext_out, ext_oe;
  logic irq_l1, irq_l2, irq_nmi;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  irq2_ctrl dut (.clk(clk), .rst(rst), .priv_i(priv_i), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tmr_ev(tmr_ev),
    .per_req(per_req), .ext_in(ext_in), .ext_out(ext_out), .ext_oe(ext_oe),
    .irq_l1(irq_l1), .irq_l2(irq_l2), .irq_nmi(irq_nmi));

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [5:0] src_vec(logic [11:0] ev, logic [3:0] pr);
    return {pr, |ev[11:6], |ev[5:0]};
  endfunction

  function automatic logic exp_lvl(logic [5:0] s, logic [5:0] en,
                                   logic [5:0] pri, logic g, logic want2);
    return g && |(s & en & (want2 ? pri : ~pri));
  endfunction

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    idle(3); rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 outputs", {2'b0, ext_oe, irq_l1, irq_l2, irq_nmi}, 8'h00);
    chk("R1 ext_out", {5'b0, ext_out}, 8'h00);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); chk("R1 R11 reg", v, 8'h00);
    end
    rd(3'd7, v); chk("R11 unused addr", v, 8'h00);

    // R10 pin levels
    ext_in = 3'b101; idle(4);
    rd(3'd6, v); chk("R10 pin level", v, 8'h05);
    ext_in = 3'b000; idle(4);
    for (int e = 0; e < 3; e++) wr(3'(e), 8'h08);

    // R2 R3 random routing
    for (int it = 0; it < 60; it++) begin
      logic [5:0] en, pri; logic [1:0] g;
      en = 6'($urandom); pri = 6'($urandom); g = 2'($urandom);
      if (it < 12) tmr_ev = 12'(1) << (it % 12);   // R2 one event at a time
      else tmr_ev = ($urandom % 3 == 0) ? 12'($urandom) : 12'h000;
      per_req = 4'($urandom);
      wr(3'd3, {2'b0, en}); wr(3'd4, {2'b0, pri}); wr(3'd5, {6'b0, g});
      idle(2);
      chk("R3 R2 level1", {7'b0, irq_l1},
          {7'b0, exp_lvl(src_vec(tmr_ev, per_req), en, pri, g[0], 1'b0)});
      chk("R3 R2 level2", {7'b0, irq_l2},
          {7'b0, exp_lvl(src_vec(tmr_ev, per_req), en, pri, g[1], 1'b1)});
    end
    tmr_ev = '0; per_req = '0;
    wr(3'd3, 8'h00); wr(3'd5, 8'h03);

    // R4 R6 rising edge on pin 1, level 1
    wr(3'd1, 8'h01);
    ext_in[1] = 1; idle(5);
    rd(3'd1, v); chk("R4 rising flag", v, 8'h09);
    chk("R6 level1 req", {6'b0, irq_l1, irq_l2}, 8'h02);
    // R5 write 0 keeps flag, write 1 clears
    wr(3'd1, 8'h01); idle(2);
    rd(3'd1, v); chk("R5 keep flag", v, 8'h09);
    wr(3'd1, 8'h09); idle(2);
    rd(3'd1, v); chk("R5 clear flag", v, 8'h01);
    chk("R6 level1 drop", {7'b0, irq_l1}, 8'h00);
    // R4 falling edge, routed to level 2
    wr(3'd1, 8'h07);
    ext_in[1] = 0; idle(5);
    rd(3'd1, v); chk("R4 falling flag", v, 8'h0f);
    chk("R6 level2 req", {6'b0, irq_l1, irq_l2}, 8'h01);
    wr(3'd5, 8'h01); idle(2);
    chk("R6 gie2 gate", {7'b0, irq_l2}, 8'h00);
    wr(3'd5, 8'h03);
    wr(3'd1, 8'h0f);
    ext_in[1] = 1; idle(5);
    rd(3'd1, v); chk("R4 wrong edge ignored", v, 8'h07);

    // R8 lock outside privilege
    priv_i = 0; wr(3'd0, 8'h80); rd(3'd0, v); chk("R8 nmi locked", v, 8'h00);
    priv_i = 1; wr(3'd0, 8'h80); rd(3'd0, v); chk("R8 nmi set", v, 8'h80);
    priv_i = 0;
    // R7 non-maskable path with enables off
    wr(3'd5, 8'h00);
    ext_in[0] = 1; idle(5);
    chk("R7 nmi", {5'b0, irq_nmi, irq_l1, irq_l2}, 8'h04);
    wr(3'd5, 8'h03); wr(3'd0, 8'h81); idle(2);
    chk("R7 not on levels", {5'b0, irq_nmi, irq_l1, irq_l2}, 8'h04);
    wr(3'd0, 8'h08); idle(2);
    chk("R7 R8 nmi bit kept", {7'b0, irq_nmi}, 8'h00);
    rd(3'd0, v); chk("R8 readback", v, 8'h80);
    priv_i = 1; wr(3'd0, 8'h00); priv_i = 0;

    // R9 gpio mode
    wr(3'd2, 8'h70); wr(3'd0, 8'h70); idle(1);
    chk("R9 oe", {5'b0, ext_oe}, 8'h04);
    chk("R9 out", {5'b0, ext_out}, 8'h05);
    ext_in[2] = 1; ext_in[0] = 0; idle(3); ext_in[2] = 0; ext_in[0] = 1; idle(5);
    rd(3'd2, v); chk("R9 no flag pin2", v, 8'h70);
    rd(3'd0, v); chk("R9 pin0 input only", v, 8'h30);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule